// File: doc/BRIEF.md
# Column Snapshot Serializing Readout Loop

This block reads out a pixel matrix with no trigger. It runs one loop over and over. In the first step it takes a snapshot of one hit from every column. Each column offers an 8-bit pixel address, an 8-bit time stamp and a valid flag. The snapshot goes into a chain of 60 sixteen-bit holding stages. In the second step the chain moves toward a serializer, one stage at a time. The serializer sends every stage's word on a single serial line. When the last word has left, a new snapshot is taken. The block never buffers data and never skips an empty column. A column without a hit is sent as the all-ones word.

Everything runs from one fast bit clock. An internal phase counter divides this clock by `DIV` (8 by default) to make the core cycle. Snapshots and chain steps happen at core-cycle boundaries. The serial line sends one bit per fast cycle, so it runs at eight times the core rate.

A loop lasts one load core cycle plus 120 shift core cycles. That is 968 fast cycles with the defaults. `load_strobe` tells the columns that their word is being taken. `frame_start` marks the fast cycle that carries the first bit of stage 0. A receiver uses it to align the frame.

Top module: `eoc_readout_loop`

## Requirements
- R1: `load_strobe` is high for exactly the first 8 fast cycles (one core cycle) of every loop and low for the rest of the loop. After reset the block starts in that load window.
- R2: A loop lasts exactly 968 fast cycles (121 core cycles). Loops follow each other with no gap.
- R3: Column i's word is taken into stage i at the clock edge that ends the load window. The stream carries the values present at that edge.
- R4: A column whose `col_valid` bit is 0 at the snapshot edge is sent as 16'hFFFF, whatever its address and time stamp.
- R5: From fast cycle 8 of the loop, the serial line carries stage 0, then stage 1, and so on up to stage 59. Each word takes 16 consecutive fast cycles and is sent MSB first, one bit per fast cycle.
- R6: `frame_start` is high for exactly one fast cycle per loop: fast cycle 8, which carries bit 15 of stage 0.
- R7: Changes on `col_addr`, `col_ts` or `col_valid` after the snapshot edge have no effect on the frame being sent.
- R8: `ser_out` is 0 during the load window.
- R9: A sent word is {address, time stamp}. Bits 15:8 are `col_addr[8i+7:8i]` and bits 7:0 are `col_ts[8i+7:8i]`.
- R10: While `rst_n` is low, `ser_out` and `frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock; the core cycle is DIV of these |
| rst_n | input | 1 | Synchronous active-low reset |
| col_addr | input | 480 | Per-column pixel address, column i at bits [8i+7:8i] |
| col_ts | input | 480 | Per-column time stamp, column i at bits [8i+7:8i] |
| col_valid | input | 60 | Per-column hit flag, bit i for column i |
| load_strobe | output | 1 | High during the load window of each loop |
| frame_start | output | 1 | High in the fast cycle carrying the first bit of stage 0 |
| ser_out | output | 1 | Serial data, MSB first, one bit per fast cycle |

## Verification
Every cycle, the assertions check the framing. The load window is exactly 8 fast cycles long. Consecutive load windows are exactly 968 fast cycles apart. `frame_start` follows the end of the load window in the next cycle and lasts one cycle. The line stays at 0 during the load window.

Only the bench's scenarios can show the payload. That covers the order of the words, the bit order within a word, the {address, time stamp} layout and the all-ones substitution for empty columns. It also covers the fact that input changes after the snapshot edge do not reach the frame. The bench checks these by rebuilding each expected frame from the stimulus it applied.

// File: rtl/eoc_pkg.sv
// Package: shared types and helpers for the column snapshot readout loop.
// Assumes an empty column is coded as an all-ones word of the configured width.
package eoc_pkg;

    typedef enum logic {
        LS_LOAD  = 1'b0,
        LS_SHIFT = 1'b1
    } loop_state_t;

    // Pick the word to store for one column: the hit word, or all ones for no hit.
    function automatic logic [15:0] pick_word16(input logic vld, input logic [15:0] w);
        return vld ? w : 16'hFFFF;
    endfunction

endpackage

// File: rtl/eoc_timebase.sv
// Module: eoc_timebase
// Makes the loop schedule from the fast clock. The fast-cycle phase counter
// divides by DIV to form the core cycle. The core-cycle counter spans one
// load cycle plus the shift cycles. The bit counter tracks the bit within
// the word being sent.
// Assumes DIV >= 2 and NCOL*WORD_W is a multiple of DIV.
module eoc_timebase
    import eoc_pkg::*;
#(
    parameter int NCOL   = 60,
    parameter int WORD_W = 16,
    parameter int DIV    = 8
) (
    input  logic                      clk_fast,
    input  logic                      rst_n,
    output loop_state_t               state,
    output logic                      capture,
    output logic                      word_end,
    output logic                      first_bit,
    output logic [$clog2(WORD_W)-1:0] bit_idx
);
    localparam int SHIFT_CORE = (NCOL * WORD_W) / DIV;
    localparam int LOOP_CORE  = SHIFT_CORE + 1;
    localparam int PH_W       = $clog2(DIV);
    localparam int CC_W       = $clog2(LOOP_CORE);
    localparam int BC_W       = $clog2(WORD_W);

    logic [PH_W-1:0] ph;
    logic [CC_W-1:0] cc;
    logic [BC_W-1:0] bc;
    logic            core_end;
    logic            in_load;

    assign core_end = (ph == PH_W'(DIV - 1));
    assign in_load  = (cc == '0);

    // Fast-cycle phase within the core cycle.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)        ph <= '0;
        else if (core_end) ph <= '0;
        else               ph <= ph + 1'b1;
    end

    // Core-cycle position within the loop; wraps back to the load cycle.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            cc <= '0;
        end else if (core_end) begin
            if (cc == CC_W'(LOOP_CORE - 1)) cc <= '0;
            else                            cc <= cc + 1'b1;
        end
    end

    // Bit position within the current word; held at zero while loading.
    always_ff @(posedge clk_fast) begin
        if (!rst_n || in_load)              bc <= '0;
        else if (bc == BC_W'(WORD_W - 1))   bc <= '0;
        else                                bc <= bc + 1'b1;
    end

    // Schedule strobes decoded from the counters.
    always_comb begin
        state     = in_load ? LS_LOAD : LS_SHIFT;
        capture   = in_load && core_end;
        word_end  = !in_load && (bc == BC_W'(WORD_W - 1));
        first_bit = (cc == CC_W'(1)) && (ph == '0);
        bit_idx   = bc;
    end

endmodule

// File: rtl/eoc_word_former.sv
// Module: eoc_word_former
// Builds each column's word as {address, time stamp}. A column with no hit
// gets all ones. Purely combinational.
// Assumes ADDR_W + TS_W = 16.
module eoc_word_former
    import eoc_pkg::*;
#(
    parameter int NCOL   = 60,
    parameter int ADDR_W = 8,
    parameter int TS_W   = 8
) (
    input  logic [NCOL*ADDR_W-1:0]        col_addr,
    input  logic [NCOL*TS_W-1:0]          col_ts,
    input  logic [NCOL-1:0]               col_valid,
    output logic [NCOL*(ADDR_W+TS_W)-1:0] words
);
    localparam int WORD_W = ADDR_W + TS_W;

    for (genvar i = 0; i < NCOL; i++) begin : g_col
        // Form one column's word with the empty-column substitution.
        always_comb begin
            words[i*WORD_W +: WORD_W] = pick_word16(col_valid[i],
                {col_addr[i*ADDR_W +: ADDR_W], col_ts[i*TS_W +: TS_W]});
        end
    end

endmodule

// File: rtl/eoc_chain.sv
// Module: eoc_chain
// A chain of NCOL holding stages. All stages load in parallel on capture.
// On advance, each stage takes the value of the next one, toward stage 0.
// All ones enter at the far end.
// Assumes capture and advance are never high together.
module eoc_chain #(
    parameter int NCOL   = 60,
    parameter int WORD_W = 16
) (
    input  logic                     clk_fast,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic                     advance,
    input  logic [NCOL*WORD_W-1:0]   words,
    output logic [WORD_W-1:0]        head
);
    localparam logic [WORD_W-1:0] EMPTY = '1;

    logic [WORD_W-1:0] stg [NCOL];

    for (genvar i = 0; i < NCOL; i++) begin : g_stage
        if (i == NCOL - 1) begin : g_last
            // Far-end stage: refilled with the empty code on every advance.
            always_ff @(posedge clk_fast) begin
                if (!rst_n)       stg[i] <= EMPTY;
                else if (capture) stg[i] <= words[i*WORD_W +: WORD_W];
                else if (advance) stg[i] <= EMPTY;
            end
        end else begin : g_mid
            // Inner stage: parallel load or step from the next stage.
            always_ff @(posedge clk_fast) begin
                if (!rst_n)       stg[i] <= EMPTY;
                else if (capture) stg[i] <= words[i*WORD_W +: WORD_W];
                else if (advance) stg[i] <= stg[i+1];
            end
        end
    end

    assign head = stg[0];

endmodule

// File: rtl/eoc_bit_serializer.sv
// Module: eoc_bit_serializer
// Picks the current bit of the head word, MSB first, while the loop is in
// its shift phase. Drives 0 during the load phase.
// Assumes bit_idx counts 0..WORD_W-1 within each word.
module eoc_bit_serializer
    import eoc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  loop_state_t               state,
    input  logic [WORD_W-1:0]         head,
    input  logic [$clog2(WORD_W)-1:0] bit_idx,
    output logic                      ser_out
);
    localparam int BC_W = $clog2(WORD_W);

    logic [BC_W-1:0] sel;

    // MSB-first bit select, gated to the shift phase.
    always_comb begin
        sel     = BC_W'(WORD_W - 1) - bit_idx;
        ser_out = (state == LS_SHIFT) ? head[sel] : 1'b0;
    end

endmodule

// File: rtl/eoc_readout_loop.sv
// Module: eoc_readout_loop (top)
// Trigger-less readout loop. It takes a snapshot of every column into a
// chain of holding stages in one core cycle. It then sends all stages
// bit-serially, one bit per fast clock, and starts again.
// Assumes the column inputs are stable around the edge that ends the load
// window.
module eoc_readout_loop
    import eoc_pkg::*;
#(
    parameter int NCOL   = 60,
    parameter int ADDR_W = 8,
    parameter int TS_W   = 8,
    parameter int DIV    = 8
) (
    input  logic                   clk_fast,
    input  logic                   rst_n,
    input  logic [NCOL*ADDR_W-1:0] col_addr,
    input  logic [NCOL*TS_W-1:0]   col_ts,
    input  logic [NCOL-1:0]        col_valid,
    output logic                   load_strobe,
    output logic                   frame_start,
    output logic                   ser_out
);
    localparam int WORD_W    = ADDR_W + TS_W;
    localparam int LOOP_FAST = DIV + NCOL * WORD_W;
    localparam int BC_W      = $clog2(WORD_W);

    loop_state_t              state;
    logic                     capture;
    logic                     word_end;
    logic                     first_bit;
    logic [BC_W-1:0]          bit_idx;
    logic [NCOL*WORD_W-1:0]   words;
    logic [WORD_W-1:0]        head;

    eoc_timebase #(.NCOL(NCOL), .WORD_W(WORD_W), .DIV(DIV)) tb_i (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .state     (state),
        .capture   (capture),
        .word_end  (word_end),
        .first_bit (first_bit),
        .bit_idx   (bit_idx)
    );

    eoc_word_former #(.NCOL(NCOL), .ADDR_W(ADDR_W), .TS_W(TS_W)) wf_i (
        .col_addr  (col_addr),
        .col_ts    (col_ts),
        .col_valid (col_valid),
        .words     (words)
    );

    eoc_chain #(.NCOL(NCOL), .WORD_W(WORD_W)) ch_i (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .capture  (capture),
        .advance  (word_end),
        .words    (words),
        .head     (head)
    );

    eoc_bit_serializer #(.WORD_W(WORD_W)) ser_i (
        .state   (state),
        .head    (head),
        .bit_idx (bit_idx),
        .ser_out (ser_out)
    );

    // Column-facing strobe and frame marker, gated quiet while in reset.
    always_comb begin
        load_strobe = (state == LS_LOAD);
        frame_start = rst_n && first_bit;
    end

endmodule

// File: rtl/eoc_readout_loop_chk.sv
// Module: eoc_readout_loop_chk
// Checker for the framing of the readout loop, bound to the top module.
// Assumes it is clocked by the same fast clock as the block.
module eoc_readout_loop_chk #(
    parameter int DIV       = 8,
    parameter int LOOP_FAST = 968
) (
    input logic clk_fast,
    input logic rst_n,
    input logic load_strobe,
    input logic frame_start,
    input logic ser_out
);
    localparam int CW = $clog2(LOOP_FAST + 1);

    logic [CW-1:0] gap;
    logic [CW-1:0] ld_len;
    logic          prev_ld;
    logic          seen;

    // Fast cycles since the last rising load strobe.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            gap <= '0; prev_ld <= 1'b0; seen <= 1'b0;
        end else begin
            prev_ld <= load_strobe;
            if (load_strobe && !prev_ld) begin
                gap <= CW'(1); seen <= 1'b1;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    // Length of the current load window in fast cycles.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)           ld_len <= '0;
        else if (load_strobe) ld_len <= ld_len + 1'b1;
        else                  ld_len <= '0;
    end

    AST_LOAD_LEN: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!load_strobe && prev_ld) |-> (ld_len == CW'(DIV))); // R1
    AST_LOOP_LEN: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (load_strobe && !prev_ld && seen) |-> (gap == CW'(LOOP_FAST))); // R2
    AST_FRAME_AFTER_LOAD: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!load_strobe && prev_ld) |-> frame_start); // R6
    AST_FRAME_SINGLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        frame_start |=> !frame_start); // R6
    AST_FRAME_NOT_IN_LOAD: assert property (@(posedge clk_fast) disable iff (!rst_n)
        frame_start |-> !load_strobe); // R1
    AST_LINE_IDLE_IN_LOAD: assert property (@(posedge clk_fast) disable iff (!rst_n)
        load_strobe |-> !ser_out); // R8

endmodule

bind eoc_readout_loop eoc_readout_loop_chk #(.DIV(DIV), .LOOP_FAST(LOOP_FAST)) chk_i (
    .clk_fast    (clk_fast),
    .rst_n       (rst_n),
    .load_strobe (load_strobe),
    .frame_start (frame_start),
    .ser_out     (ser_out)
);

// File: tb/eoc_readout_loop_tb_top.sv
// Bench for eoc_readout_loop. It applies random and directed column patterns
// with a fixed seed. It rebuilds each expected frame from the applied
// stimulus and compares every fast cycle's outputs at the falling edge.
module eoc_readout_loop_tb_top;
    localparam int NCOL  = 60;
    localparam int LOOPF = 968;
    localparam int NLOOP = 6;

    logic              clk_fast = 1'b0;
    logic              rst_n    = 1'b0;
    logic [NCOL*8-1:0] col_addr;
    logic [NCOL*8-1:0] col_ts;
    logic [NCOL-1:0]   col_valid;
    logic              load_strobe, frame_start, ser_out;

    logic [7:0]  a_m [NCOL];
    logic [7:0]  t_m [NCOL];
    logic        v_m [NCOL];
    logic [15:0] snap [NCOL];
    logic        snap_v [NCOL];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    bit scrambled = 0;

    always #2 clk_fast = ~clk_fast;

    eoc_readout_loop dut_i (
        .clk_fast(clk_fast), .rst_n(rst_n), .col_addr(col_addr), .col_ts(col_ts),
        .col_valid(col_valid), .load_strobe(load_strobe),
        .frame_start(frame_start), .ser_out(ser_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < NCOL; i++) begin
            col_addr[i*8 +: 8] = a_m[i];
            col_ts[i*8 +: 8]   = t_m[i];
            col_valid[i]       = v_m[i];
        end
    endtask

    // Pattern n selects the stimulus kind for a loop.
    task automatic set_pattern(input int n);
        for (int i = 0; i < NCOL; i++) begin
            a_m[i] = 8'($urandom);
            t_m[i] = 8'($urandom);
            case (n % 4)
                0: v_m[i] = 1'b1;                      // all hit
                1: v_m[i] = 1'b0;                      // all empty (R4)
                2: v_m[i] = 1'($urandom);              // random mix
                default: begin                         // directed corners
                    a_m[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
                    t_m[i] = (i % 3 == 0) ? 8'h00 : 8'hFF;
                    v_m[i] = (i != NCOL - 1) && (i != 1);
                end
            endcase
        end
        drive();
    endtask

    // Expected stored word for a column, R4 and R9.
    function automatic logic [15:0] exp_word(input int i);
        return v_m[i] ? {a_m[i], t_m[i]} : 16'hFFFF;
    endfunction

    initial begin
        void'($urandom(32'd5150));
        set_pattern(0);
        for (int r = 0; r < 5; r++) begin
            @(negedge clk_fast);
            chk(ser_out == 1'b0, "R10 ser_out in reset", int'(ser_out), 0);
            chk(frame_start == 1'b0, "R10 frame_start in reset", int'(frame_start), 0);
        end
        @(negedge clk_fast);
        rst_n = 1'b1;
        for (int t = 0; t < NLOOP * LOOPF + 20; t++) begin
            int tl, lp;
            tl = t % LOOPF;
            lp = t / LOOPF;
            chk(load_strobe == (tl < 8), (tl == 0 && lp > 0) ? "R2 loop restart" : "R1 load_strobe",
                int'(load_strobe), int'(tl < 8));
            chk(frame_start == (tl == 8), "R6 frame_start", int'(frame_start), int'(tl == 8));
            if (tl < 8) begin
                chk(ser_out == 1'b0, "R8 idle line in load", int'(ser_out), 0);
            end else begin
                int k, w, b;
                string tag;
                k = tl - 8; w = k / 16; b = 15 - (k % 16);
                tag = !snap_v[w] ? "R4 empty word" : (scrambled ? "R7 input ignored" : "R3,R5,R9 word bit");
                chk(ser_out == snap[w][b], tag, int'(ser_out), int'(snap[w][b]));
            end
            if (tl == 7) begin
                scrambled = 0;
                for (int i = 0; i < NCOL; i++) begin
                    snap[i]   = exp_word(i);
                    snap_v[i] = v_m[i];
                end
            end
            if ((tl == 8 || tl == 500) && (lp % 2 == 0)) begin
                set_pattern(2);
                scrambled = 1;
            end
            if (tl == LOOPF - 1) set_pattern(lp + 1);
            @(negedge clk_fast);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule